// File: doc/BRIEF.md
# SPI Real-Time-Clock Access Sequencer

This block is a hardware master that fetches and loads calendar time in an external real-time-clock chip over a four-wire serial link. The host side starts a fetch with `rdReq` or a load with `setReq` and gets a one-cycle `done` pulse at the end. A fetch returns binary seconds, minutes, hours (0 to 23), day of week, day of month, month and a full four-digit year. A load takes the same fields in binary. On the device side the block drives an active-high chip enable, a serial clock that idles low and a data-out line. It samples a data-in line.

A fetch is one chip-enable window: the time base address is sent, then seven BCD bytes are read in a burst. A load is three windows. The first clears the chip's write-protect flag. The second writes the seven time bytes as BCD, starting at the write base address. The third sets write-protect again. The chip may report the hour in 12-hour or 24-hour form, and the block converts either one to a 0 to 23 value. Years are stored on the chip as two digits and are offset by 2000 on the host side.

Top module: `rtc_spi_seq`

## Requirements
- R1: After reset `ce`, `sck`, `mosi` and `done` are all low.
- R2: Bytes are shifted most significant bit first, eight bits per byte. `sck` idles low, and each high or low half lasts HALF_CYCLES clocks. On every bit `sck` rises first and `mosi` changes one clock later, while `sck` is still high. `miso` is captured at the end of the high half.
- R3: `ce` is active high. At least SETTLE_CYCLES clocks separate each `ce` edge from `sck` activity. Between two windows `ce` stays low for at least SETTLE_CYCLES clocks.
- R4: A fetch is one window. It sends byte 0x00, then reads seven bytes in this order: seconds, minutes, hours, day of week, day of month, month, year. `done` is high exactly 2*SETTLE_CYCLES+128*HALF_CYCLES clocks after the clock edge that accepts the request.
- R5: A load is three windows. The bytes are [0x8F, 0x00], then [0x80, seven BCD time bytes in the R4 order], then [0x8F, 0x40]. The hour is written in 24-hour form (bit 6 clear). `done` is high exactly 6*SETTLE_CYCLES+192*HALF_CYCLES clocks after the accepting edge.
- R6: Bytes read from the chip are BCD, with tens in bits 7:4 and units in bits 3:0. Written bytes are binary values converted to that same BCD form.
- R7: When bit 6 of the hour byte is clear, bits 5:0 are a 24-hour BCD hour and are returned unchanged in value.
- R8: When bit 6 of the hour byte is set, bit 5 means PM and bits 4:0 hold a BCD hour from 1 to 12. 12 AM returns 0, 1 to 11 AM are returned as is, 12 PM returns 12, and 1 to 11 PM return 13 to 23.
- R9: The year returned is 2000 plus the two-digit chip year. The year written is the host year minus 2000.
- R10: A request that arrives while a transfer is running is ignored. If `rdReq` and `setReq` are both high in the same idle cycle, the fetch runs.
- R11: `done` lasts exactly one cycle. The fetch results are valid in the same cycle and hold until the next fetch completes. A load leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Start a time fetch |
| setReq | input | 1 | Start a time load |
| wrSec | input | 6 | Seconds to load, binary |
| wrMin | input | 6 | Minutes to load, binary |
| wrHour | input | 5 | Hour to load, 0 to 23 |
| wrWday | input | 3 | Day of week to load |
| wrMday | input | 5 | Day of month to load |
| wrMon | input | 4 | Month to load |
| wrYear | input | 12 | Full year to load, 2000 to 2099 |
| done | output | 1 | One-cycle completion pulse |
| rdSec | output | 6 | Fetched seconds |
| rdMin | output | 6 | Fetched minutes |
| rdHour | output | 5 | Fetched hour, 0 to 23 |
| rdWday | output | 3 | Fetched day of week |
| rdMday | output | 5 | Fetched day of month |
| rdMon | output | 4 | Fetched month |
| rdYear | output | 12 | Fetched full year |
| ce | output | 1 | Chip enable to the clock chip, active high |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the chip |
| miso | input | 1 | Serial data from the chip |

## Verification
The bench times each request from its accepting clock edge. With HALF_CYCLES=4 and SETTLE_CYCLES=4, a fetch raises `done` 520 clocks later and a load 792 clocks later. Both `done` and the fetched fields are sampled on the falling clock edge in exactly that cycle, and `done` is checked low one cycle after. The serial timing (the width of the `sck` high half, the delay from `ce` rise to the first `sck` rise, and the gap while `ce` is low) is measured cycle by cycle by a monitor on the falling clock edge. The bytes each window carried are checked through a model of the chip's register file after `done`.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

  localparam int unsigned NUM_TIME_BYTES = 7;
  localparam logic [7:0] ADDR_TIME_RD  = 8'h00;
  localparam logic [7:0] ADDR_TIME_WR  = 8'h80;
  localparam logic [7:0] ADDR_CTRL_WR  = 8'h8F;
  localparam logic [7:0] CTRL_UNLOCKED = 8'h00;
  localparam logic [7:0] CTRL_LOCKED   = 8'h40;
  localparam logic [11:0] YEAR_BASE    = 12'd2000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CE_ON, ST_BIT_HI, ST_BIT_LO, ST_CE_OFF
  } seqState_t;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic       latch;    // capture host write fields
    logic       drive;    // update mosi with current bit
    logic       sample;   // shift in miso
    logic       store;    // commit received byte
    logic       publish;  // update host read fields
    logic       isSet;
    logic [1:0] txn;
    logic [2:0] byteIdx;
    logic [2:0] bitIdx;
  } seqStrobe_t;

  function automatic logic [6:0] fromBcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [4:0] decodeHour(input logic [7:0] h);
    logic [6:0] v;
    if (h[6]) begin
      v = fromBcd({3'b000, h[4:0]});
      if (v == 7'd12) v = h[5] ? 7'd12 : 7'd0;
      else if (h[5]) v = v + 7'd12;
    end else begin
      v = fromBcd({2'b00, h[5:0]});
    end
    return v[4:0];
  endfunction

endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
#(
  parameter int unsigned HALF_CYCLES   = 4,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       setReq,
  output seqStrobe_t stb,
  output logic       ce,
  output logic       sck,
  output logic       done
);
  localparam int unsigned MAXC = (HALF_CYCLES > SETTLE_CYCLES) ? HALF_CYCLES : SETTLE_CYCLES;
  localparam int unsigned TW = $clog2(MAXC) + 1;
  localparam logic [TW-1:0] HALF_LD   = TW'(HALF_CYCLES - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYCLES - 1);

  seqState_t     state;
  logic [TW-1:0] timer;
  logic          isSet;
  logic [1:0]    txn;
  logic [2:0]    byteIdx;
  logic [2:0]    bitIdx;
  logic          timerZero;
  logic [2:0]    lastByte;

  assign timerZero = (timer == '0);
  // address plus control byte outside the burst window, address plus burst inside
  assign lastByte  = (isSet && txn != 2'd1) ? 3'd1 : 3'd7;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      isSet   <= 1'b0;
      txn     <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!timerZero) timer <= timer - 1'b1;
      unique case (state)
        ST_IDLE: if (rdReq || setReq) begin
          isSet   <= !rdReq;
          txn     <= '0;
          byteIdx <= '0;
          bitIdx  <= '0;
          timer   <= SETTLE_LD;
          state   <= ST_CE_ON;
        end
        ST_CE_ON: if (timerZero) begin
          timer <= HALF_LD;
          state <= ST_BIT_HI;
        end
        ST_BIT_HI: if (timerZero) begin
          timer <= HALF_LD;
          state <= ST_BIT_LO;
        end
        ST_BIT_LO: if (timerZero) begin
          if (bitIdx != 3'd7) begin
            bitIdx <= bitIdx + 1'b1;
            timer  <= HALF_LD;
            state  <= ST_BIT_HI;
          end else begin
            bitIdx <= '0;
            if (byteIdx == lastByte) begin
              timer <= SETTLE_LD;
              state <= ST_CE_OFF;
            end else begin
              byteIdx <= byteIdx + 1'b1;
              timer   <= HALF_LD;
              state   <= ST_BIT_HI;
            end
          end
        end
        ST_CE_OFF: if (timerZero) begin
          if (isSet && txn != 2'd2) begin
            txn     <= txn + 1'b1;
            byteIdx <= '0;
            timer   <= SETTLE_LD;
            state   <= ST_CE_ON;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ce  = (state == ST_CE_ON) || (state == ST_BIT_HI) || (state == ST_BIT_LO);
  assign sck = (state == ST_BIT_HI);

  always_comb begin
    stb         = '0;
    stb.latch   = (state == ST_IDLE) && (rdReq || setReq);
    stb.drive   = (state == ST_BIT_HI) && (timer == HALF_LD);
    stb.sample  = (state == ST_BIT_HI) && timerZero;
    stb.store   = (state == ST_BIT_LO) && timerZero && (bitIdx == 3'd7) && !isSet && (byteIdx != 3'd0);
    stb.publish = (state == ST_CE_OFF) && timerZero && !isSet;
    stb.isSet   = isSet;
    stb.txn     = txn;
    stb.byteIdx = byteIdx;
    stb.bitIdx  = bitIdx;
  end

endmodule

// File: rtl/rtc_spi_dp.sv
module rtc_spi_dp
  import rtc_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  stb,
  input  logic        miso,
  input  logic [5:0]  wrSec,
  input  logic [5:0]  wrMin,
  input  logic [4:0]  wrHour,
  input  logic [2:0]  wrWday,
  input  logic [4:0]  wrMday,
  input  logic [3:0]  wrMon,
  input  logic [11:0] wrYear,
  output logic        mosi,
  output logic [5:0]  rdSec,
  output logic [5:0]  rdMin,
  output logic [4:0]  rdHour,
  output logic [2:0]  rdWday,
  output logic [4:0]  rdMday,
  output logic [3:0]  rdMon,
  output logic [11:0] rdYear
);
  logic [7:0] wrBcd [NUM_TIME_BYTES];
  logic [7:0] rxRaw [NUM_TIME_BYTES];
  logic [7:0] rxShift;
  logic [7:0] txByte;
  logic [2:0] slot;

  assign slot = stb.byteIdx - 3'd1;

  always_comb begin
    txByte = ADDR_TIME_RD;
    if (stb.isSet) begin
      unique case (stb.txn)
        2'd0:    txByte = (stb.byteIdx == 3'd0) ? ADDR_CTRL_WR : CTRL_UNLOCKED;
        2'd1:    txByte = (stb.byteIdx == 3'd0) ? ADDR_TIME_WR : wrBcd[slot];
        default: txByte = (stb.byteIdx == 3'd0) ? ADDR_CTRL_WR : CTRL_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mosi    <= 1'b0;
      rxShift <= '0;
      for (int i = 0; i < NUM_TIME_BYTES; i++) begin
        wrBcd[i] <= '0;
        rxRaw[i] <= '0;
      end
      rdSec  <= '0;
      rdMin  <= '0;
      rdHour <= '0;
      rdWday <= '0;
      rdMday <= '0;
      rdMon  <= '0;
      rdYear <= '0;
    end else begin
      if (stb.latch) begin
        wrBcd[0] <= toBcd(7'(wrSec));
        wrBcd[1] <= toBcd(7'(wrMin));
        wrBcd[2] <= toBcd(7'(wrHour));
        wrBcd[3] <= toBcd(7'(wrWday));
        wrBcd[4] <= toBcd(7'(wrMday));
        wrBcd[5] <= toBcd(7'(wrMon));
        wrBcd[6] <= toBcd(7'(wrYear - YEAR_BASE));
      end
      if (stb.drive)  mosi <= txByte[3'd7 - stb.bitIdx];
      if (stb.sample) rxShift <= {rxShift[6:0], miso};
      if (stb.store)  rxRaw[slot] <= rxShift;
      if (stb.publish) begin
        rdSec  <= 6'(fromBcd(rxRaw[0]));
        rdMin  <= 6'(fromBcd(rxRaw[1]));
        rdHour <= decodeHour(rxRaw[2]);
        rdWday <= 3'(fromBcd(rxRaw[3]));
        rdMday <= 5'(fromBcd(rxRaw[4]));
        rdMon  <= 4'(fromBcd(rxRaw[5]));
        rdYear <= YEAR_BASE + 12'(fromBcd(rxRaw[6]));
      end
    end
  end

endmodule

// File: rtl/rtc_spi_seq.sv
module rtc_spi_seq
  import rtc_spi_pkg::*;
#(
  parameter int unsigned HALF_CYCLES   = 4,  // must be at least 2
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic        setReq,
  input  logic [5:0]  wrSec,
  input  logic [5:0]  wrMin,
  input  logic [4:0]  wrHour,
  input  logic [2:0]  wrWday,
  input  logic [4:0]  wrMday,
  input  logic [3:0]  wrMon,
  input  logic [11:0] wrYear,
  output logic        done,
  output logic [5:0]  rdSec,
  output logic [5:0]  rdMin,
  output logic [4:0]  rdHour,
  output logic [2:0]  rdWday,
  output logic [4:0]  rdMday,
  output logic [3:0]  rdMon,
  output logic [11:0] rdYear,
  output logic        ce,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  seqStrobe_t stb;

  rtc_spi_ctrl #(
    .HALF_CYCLES  (HALF_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rdReq (rdReq),
    .setReq(setReq),
    .stb   (stb),
    .ce    (ce),
    .sck   (sck),
    .done  (done)
  );

  rtc_spi_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .miso  (miso),
    .wrSec (wrSec),
    .wrMin (wrMin),
    .wrHour(wrHour),
    .wrWday(wrWday),
    .wrMday(wrMday),
    .wrMon (wrMon),
    .wrYear(wrYear),
    .mosi  (mosi),
    .rdSec (rdSec),
    .rdMin (rdMin),
    .rdHour(rdHour),
    .rdWday(rdWday),
    .rdMday(rdMday),
    .rdMon (rdMon),
    .rdYear(rdYear)
  );

endmodule

// File: rtl/rtc_spi_seq_chk.sv
module rtc_spi_seq_chk #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic ce,
  input logic sck,
  input logic mosi,
  input logic done
);
  logic [15:0] lowRun;

  // counts consecutive clocks with chip enable low, saturating
  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= 16'hFFFF;
    else if (ce) lowRun <= '0;
    else if (lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
  end

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ce |-> !sck);

  p_mosi_in_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mosi) |-> (sck && $past(sck)));

  p_ce_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $past(ce));

  p_ce_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ce) |-> !$past(sck));

  p_ce_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ce) |-> ($past(lowRun) >= 16'(SETTLE_CYCLES - 1)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!ce && !sck));

endmodule

bind rtc_spi_seq rtc_spi_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk (clk),
  .rstN(rstN),
  .ce  (ce),
  .sck (sck),
  .mosi(mosi),
  .done(done)
);

// File: tb/rtc_spi_seq_tb.sv
`timescale 1ns/1ps
module rtc_spi_seq_tb;
  localparam int H = 4;
  localparam int S = 4;
  localparam int READ_LAT = 2*S + 128*H + 1;  // posedges counted from the accepting edge
  localparam int SET_LAT  = 6*S + 192*H + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdReq = 1'b0, setReq = 1'b0;
  logic [5:0] wrSec = '0, wrMin = '0;
  logic [4:0] wrHour = '0, wrMday = '0;
  logic [2:0] wrWday = '0;
  logic [3:0] wrMon = '0;
  logic [11:0] wrYear = 12'd2000;
  logic done;
  logic [5:0] rdSec, rdMin;
  logic [4:0] rdHour, rdMday;
  logic [2:0] rdWday;
  logic [3:0] rdMon;
  logic [11:0] rdYear;
  logic ce, sck, mosi;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  rtc_spi_seq #(.HALF_CYCLES(H), .SETTLE_CYCLES(S)) u_dut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .setReq(setReq),
    .wrSec(wrSec), .wrMin(wrMin), .wrHour(wrHour), .wrWday(wrWday),
    .wrMday(wrMday), .wrMon(wrMon), .wrYear(wrYear), .done(done),
    .rdSec(rdSec), .rdMin(rdMin), .rdHour(rdHour), .rdWday(rdWday),
    .rdMday(rdMday), .rdMon(rdMon), .rdYear(rdYear),
    .ce(ce), .sck(sck), .mosi(mosi), .miso(miso));

  int nRun = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------- behavioural clock-chip model ----------
  logic [7:0] regs [16];
  logic [7:0] seen [4][8];
  int seenLen [4];
  int txnCnt = 0;
  int bitCnt = 0, byteCnt = 0;
  logic [7:0] inByte = '0, outByte = '0, addr = '0;
  logic [3:0] ptr = '0;

  always @(posedge ce) begin
    bitCnt = 0; byteCnt = 0; txnCnt++;
  end

  always @(negedge sck) if (ce) begin
    inByte = {inByte[6:0], mosi};
    bitCnt++;
    if (bitCnt == 8) begin
      bitCnt = 0;
      if (txnCnt >= 1 && txnCnt <= 4 && byteCnt < 8) begin
        seen[txnCnt-1][byteCnt] = inByte;
        seenLen[txnCnt-1] = byteCnt + 1;
      end
      if (byteCnt == 0) begin
        addr = inByte; ptr = inByte[3:0];
      end else if (addr[7]) begin
        if (ptr == 4'hF || !regs[15][6]) regs[ptr] = inByte;
        ptr++;
      end
      byteCnt++;
      if (!addr[7]) begin
        outByte = regs[ptr]; ptr++; miso = outByte[7];
      end
    end else if (!addr[7] && byteCnt > 0) begin
      miso = outByte[7-bitCnt];
    end
  end

  // ---------- serial timing monitor ----------
  int hiRun = 0, hiMin = 1000, hiMax = 0;
  int ceRun = 0, setupMin = 1000;
  int loRun = 0, gapMin = 1000;
  bit sckSeen = 0, prevCe = 0, prevSck = 0, gapArm = 0;
  always @(negedge clk) begin
    if (sck) hiRun++;
    else if (hiRun > 0) begin
      if (hiRun < hiMin) hiMin = hiRun;
      if (hiRun > hiMax) hiMax = hiRun;
      hiRun = 0;
    end
    if (ce && !prevCe) begin
      if (gapArm && loRun < gapMin) gapMin = loRun;
      ceRun = 0; sckSeen = 0;
    end
    if (ce) begin
      ceRun++;
      if (sck && !prevSck && !sckSeen) begin
        sckSeen = 1;
        if (ceRun - 1 < setupMin) setupMin = ceRun - 1;
      end
    end
    if (!ce && prevCe) begin gapArm = 1; loRun = 0; end
    if (!ce) loRun++;
    prevCe = ce; prevSck = sck;
  end

  task automatic clearLog();
    txnCnt = 0;
    for (int i = 0; i < 4; i++) seenLen[i] = 0;
    gapArm = 0;
  endtask

  // pulse requests, return posedges from accepting edge until done is seen
  task automatic request(input bit rd, input bit st, output int lat);
    @(negedge clk); rdReq = rd; setReq = st;
    @(negedge clk); rdReq = 1'b0; setReq = 1'b0; lat = 1;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  typedef struct packed {
    logic [7:0] rs, rm, rh, rw, rd, rmo, ry;
    logic [5:0] es, em;
    logic [4:0] eh;
    logic [2:0] ew;
    logic [4:0] ed;
    logic [3:0] emo;
    logic [11:0] ey;
  } vec_t;

  // raw chip bytes and the binary result expected from each
  localparam vec_t VEC [7] = '{
    '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 6'd59, 6'd59, 5'd23, 3'd7, 5'd31, 4'd12, 12'd2099},
    '{8'h00, 8'h30, 8'h52, 8'h01, 8'h01, 8'h01, 8'h00, 6'd0,  6'd30, 5'd0,  3'd1, 5'd1,  4'd1,  12'd2000},
    '{8'h07, 8'h45, 8'h72, 8'h02, 8'h15, 8'h06, 8'h42, 6'd7,  6'd45, 5'd12, 3'd2, 5'd15, 4'd6,  12'd2042},
    '{8'h33, 8'h01, 8'h71, 8'h03, 8'h09, 8'h10, 8'h18, 6'd33, 6'd1,  5'd23, 3'd3, 5'd9,  4'd10, 12'd2018},
    '{8'h10, 8'h20, 8'h41, 8'h04, 8'h28, 8'h02, 8'h24, 6'd10, 6'd20, 5'd1,  3'd4, 5'd28, 4'd2,  12'd2024},
    '{8'h48, 8'h12, 8'h67, 8'h05, 8'h30, 8'h11, 8'h77, 6'd48, 6'd12, 5'd19, 3'd5, 5'd30, 4'd11, 12'd2077},
    '{8'h01, 8'h02, 8'h09, 8'h06, 8'h19, 8'h08, 8'h05, 6'd1,  6'd2,  5'd9,  3'd6, 5'd19, 4'd8,  12'd2005}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int lat;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    regs[15] = 8'h40;
    repeat (3) @(negedge clk);
    check(!ce && !sck && !mosi && !done, "R1", "reset outputs",
          {ce, sck, mosi, done}, 0);
    rstN = 1'b1;

    // table walk: fetches
    foreach (VEC[i]) begin
      regs[0] = VEC[i].rs; regs[1] = VEC[i].rm; regs[2] = VEC[i].rh;
      regs[3] = VEC[i].rw; regs[4] = VEC[i].rd; regs[5] = VEC[i].rmo;
      regs[6] = VEC[i].ry;
      clearLog();
      request(1'b1, 1'b0, lat);
      check(lat == READ_LAT, "R4", "fetch latency", lat, READ_LAT);
      check(rdSec == VEC[i].es && rdMin == VEC[i].em && rdWday == VEC[i].ew &&
            rdMday == VEC[i].ed && rdMon == VEC[i].emo, "R6", "BCD fields",
            {rdSec, rdMin, rdWday, rdMday, rdMon},
            {VEC[i].es, VEC[i].em, VEC[i].ew, VEC[i].ed, VEC[i].emo});
      check(rdHour == VEC[i].eh, VEC[i].rh[6] ? "R8" : "R7", "hour decode",
            rdHour, VEC[i].eh);
      check(rdYear == VEC[i].ey, "R9", "year", rdYear, VEC[i].ey);
      check(txnCnt == 1 && seenLen[0] == 8 && seen[0][0] == 8'h00, "R4",
            "fetch window", {txnCnt[7:0], seenLen[0][7:0], seen[0][0]}, 24'h010800);
      @(negedge clk);
      check(!done, "R11", "done width", done, 0);
    end

    check(hiMin == H && hiMax == H, "R2", "sck high width", {hiMin[15:0], hiMax[15:0]}, {H[15:0], H[15:0]});
    check(setupMin >= S, "R3", "ce to sck setup", setupMin, S);

    // load
    wrSec = 6'd45; wrMin = 6'd7; wrHour = 5'd18; wrWday = 3'd3;
    wrMday = 5'd28; wrMon = 4'd2; wrYear = 12'd2024;
    clearLog(); gapMin = 1000;
    request(1'b0, 1'b1, lat);
    check(lat == SET_LAT, "R5", "load latency", lat, SET_LAT);
    check(rdYear == 12'd2005 && rdHour == 5'd9, "R11", "fetch fields kept", {rdYear, rdHour}, {12'd2005, 5'd9});
    check(txnCnt == 3, "R5", "window count", txnCnt, 3);
    check(seenLen[0] == 2 && seen[0][0] == 8'h8F && seen[0][1] == 8'h00, "R5", "unlock window",
          {seenLen[0][7:0], seen[0][0], seen[0][1]}, 24'h028F00);
    check(seenLen[1] == 8 && seen[1][0] == 8'h80, "R5", "burst header",
          {seenLen[1][7:0], seen[1][0]}, 16'h0880);
    check(seenLen[2] == 2 && seen[2][0] == 8'h8F && seen[2][1] == 8'h40, "R5", "relock window",
          {seenLen[2][7:0], seen[2][0], seen[2][1]}, 24'h028F40);
    check({regs[0], regs[1], regs[2], regs[3], regs[4], regs[5], regs[6]} == 56'h45071803280224,
          "R6", "written BCD", {regs[0], regs[1], regs[2], regs[3], regs[4], regs[5], regs[6]},
          56'h45071803280224);
    check(regs[15] == 8'h40, "R5", "write protect restored", regs[15], 8'h40);
    check(gapMin >= S, "R3", "ce low gap", gapMin, S);

    // round trip back through a fetch
    clearLog();
    request(1'b1, 1'b0, lat);
    check(rdSec == 6'd45 && rdMin == 6'd7 && rdHour == 5'd18 && rdYear == 12'd2024,
          "R9", "round trip", {rdSec, rdMin, rdHour, rdYear}, {6'd45, 6'd7, 5'd18, 12'd2024});

    // both requests together: fetch wins
    clearLog(); regs[2] = 8'h71;
    request(1'b1, 1'b1, lat);
    check(lat == READ_LAT && txnCnt == 1, "R10", "simultaneous requests",
          {lat[15:0], txnCnt[7:0]}, {READ_LAT[15:0], 8'd1});

    // requests while busy are ignored
    clearLog(); wrSec = 6'd11;
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0; lat = 1;
    repeat (100) begin @(negedge clk); lat++; end
    setReq = 1'b1; @(negedge clk); lat++; setReq = 1'b0;
    repeat (50) begin @(negedge clk); lat++; end
    rdReq = 1'b1; @(negedge clk); lat++; rdReq = 1'b0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    check(lat == READ_LAT, "R10", "busy fetch latency", lat, READ_LAT);
    lat = 0;
    repeat (1000) begin @(negedge clk); if (done) lat++; end
    check(lat == 0 && txnCnt == 1 && regs[0] == 8'h45, "R10", "busy requests dropped",
          {lat[7:0], txnCnt[7:0], regs[0]}, 24'h000145);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule